// File: doc/BRIEF.md
# Tile Matrix Multiply-Accumulate Unit

This block holds a small file of two-dimensional tile registers and runs one operation on them: a signed 8-bit matrix product that is added into a destination tile of 32-bit accumulators, C += A·B. Software-side logic first fills tiles through a row-wide write port and can inspect any row through a combinational read port. A command then names the destination tile and the two source tiles, and the block computes and writes back one full row of C per cycle. Each row is also streamed out on a result port.

Each tile has ROWS rows of 4·ROWS bytes. The default is 16 rows of 64 bytes, with 8 tiles. Tile A is read as ROWS×K signed bytes, with K = 4·ROWS. Byte j of row n is A[n][j]. Tile B is read in groups of four: byte 4·m+q of row r is B[4·r+q][m]. That gives a K×ROWS operand. Tile C holds ROWS×ROWS signed 32-bit words, and element m of row n sits in bits [32·m+31 : 32·m].

A full operation takes ROWS compute cycles and does ROWS·ROWS·K multiplies. A command whose destination equals one of its sources gives an undefined result.

Top module: `tile_mac_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, busy, done and res_valid are 0.
- R2: When the block is idle, a wr_en write of a row shows on rd_data when that tile and row are selected, and stays there until something writes that row again.
- R3: An operation leaves every destination element at C[n][m] + Σj A[n][j]·B[j][m]. It uses the A/B byte layout and the C word layout stated above, with signed bytes, and the result is an addition to the old value, never a replacement. Repeated operations on the same C keep adding.
- R4: Operands that are all -128 (byte 0x80) give a product term of +16384 each. With ROWS=4 a zeroed C therefore becomes 262144 in every element.
- R5: The accumulators wrap modulo 2^32. For example, 0x7FFFFFF0 plus 262144 reads back as 0x8003FFF0.
- R6: An idle start raises busy on the next cycle. busy then stays high for exactly ROWS cycles. done is high for exactly one cycle, the cycle in which busy has just fallen.
- R7: start is ignored while busy. It neither restarts the operation nor queues a second one.
- R8: wr_en is ignored while busy. The addressed row keeps its old contents.
- R9: During an operation res_valid is high on ROWS consecutive cycles. res_row counts 0,1,…,ROWS-1, and res_data equals the row just written to the destination.
- R10: A write accepted in the same cycle as an idle start takes effect before the computation reads the tile, so the new data is used.
- R11: An operation leaves the source tiles and every tile other than the destination unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Row write request (idle only) |
| wr_tile | input | log2(NTILE) | Tile written |
| wr_row | input | log2(ROWS) | Row written |
| wr_data | input | 32·ROWS | Row data |
| rd_tile | input | log2(NTILE) | Tile read |
| rd_row | input | log2(ROWS) | Row read |
| rd_data | output | 32·ROWS | Selected row, combinational |
| start | input | 1 | Launch request (idle only) |
| cmd_dst | input | log2(NTILE) | Destination tile C |
| cmd_a | input | log2(NTILE) | Source tile A |
| cmd_b | input | log2(NTILE) | Source tile B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | A result row was written this cycle |
| res_row | output | log2(ROWS) | Index of that row |
| res_data | output | 32·ROWS | Contents of that row |

## Verification
Two functions can land in the same cycle: a row write and a start. They can coincide on an idle cycle, and a write or a second start can also arrive while a computation is running. The bench raises wr_en together with an idle start and expects the freshly written A row to appear in the first streamed row. It then injects a write and a second start partway through an operation and expects the written row to read back unchanged and busy to stay low after done. Every expected C row is recomputed arithmetically from a bench copy of the tiles, across a sweep of every destination/source combination with distinct destination.

// File: rtl/tile_mac_unit.sv
module tile_mac_unit #(
  parameter int NTILE = 8,
  parameter int ROWS  = 16,
  localparam int TW   = $clog2(NTILE),
  localparam int RW   = $clog2(ROWS),
  localparam int K    = 4 * ROWS,
  localparam int W    = 8 * K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_tile,
  input  logic [RW-1:0] wr_row,
  input  logic [W-1:0]  wr_data,
  input  logic [TW-1:0] rd_tile,
  input  logic [RW-1:0] rd_row,
  output logic [W-1:0]  rd_data,
  input  logic          start,
  input  logic [TW-1:0] cmd_dst,
  input  logic [TW-1:0] cmd_a,
  input  logic [TW-1:0] cmd_b,
  output logic          busy,
  output logic          done,
  output logic          res_valid,
  output logic [RW-1:0] res_row,
  output logic [W-1:0]  res_data
);

  logic [W-1:0] tiles [0:NTILE*ROWS-1];
  logic [TW-1:0] dst_q, a_q, b_q;
  logic [RW-1:0] row;
  logic [W-1:0] a_row, c_row, c_new;

  assign rd_data = tiles[{rd_tile, rd_row}];
  assign a_row   = tiles[{a_q, row}];
  assign c_row   = tiles[{dst_q, row}];

  for (genvar m = 0; m < ROWS; m++) begin : g_col
    int acc;
    always_comb begin
      acc = int'(c_row[32*m +: 32]);
      for (int j = 0; j < K; j++) begin
        acc = acc + int'($signed(a_row[8*j +: 8])) *
                    int'($signed(tiles[{b_q, RW'(j / 4)}][8*(4*m + j % 4) +: 8]));
      end
    end
    assign c_new[32*m +: 32] = acc;
  end

  always_ff @(posedge clk) begin
    if (busy)       tiles[{dst_q, row}]    <= c_new;
    else if (wr_en) tiles[{wr_tile, wr_row}] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      res_row   <= '0;
      res_data  <= '0;
      row       <= '0;
      dst_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
    end else begin
      done      <= 1'b0;
      res_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          row   <= '0;
          dst_q <= cmd_dst;
          a_q   <= cmd_a;
          b_q   <= cmd_b;
        end
      end else begin
        res_valid <= 1'b1;
        res_row   <= row;
        res_data  <= c_new;
        row       <= row + 1'b1;
        if (row == RW'(ROWS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

module tile_mac_chk #(
  parameter int ROWS = 16,
  parameter int RW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          res_valid,
  input logic [RW-1:0] res_row
);

  logic [15:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == 16'(ROWS));
  a_r9_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));
  a_r9_first_row: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(res_valid)) |-> res_row == '0);
  a_r9_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid)) |-> res_row == RW'($past(res_row) + 1'b1));

endmodule

bind tile_mac_unit tile_mac_chk #(.ROWS(ROWS), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .res_valid(res_valid), .res_row(res_row)
);

// File: tb/sim_tile_mac_unit.sv
`timescale 1ns/1ps
module sim_tile_mac_unit;
  localparam int NT   = 8;
  localparam int ROWS = 4;
  localparam int K    = 4 * ROWS;
  localparam int W    = 8 * K;
  localparam int TW   = $clog2(NT);
  localparam int RW   = $clog2(ROWS);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [TW-1:0] wr_tile = 0, rd_tile = 0, cmd_dst = 0, cmd_a = 0, cmd_b = 0;
  logic [RW-1:0] wr_row = 0, rd_row = 0, res_row;
  logic [W-1:0]  wr_data = 0, rd_data, res_data;
  logic busy, done, res_valid;

  always #2.5 clk = ~clk;

  tile_mac_unit #(.NTILE(NT), .ROWS(ROWS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tile(wr_tile), .wr_row(wr_row),
    .wr_data(wr_data), .rd_tile(rd_tile), .rd_row(rd_row), .rd_data(rd_data),
    .start(start), .cmd_dst(cmd_dst), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .done(done), .res_valid(res_valid), .res_row(res_row), .res_data(res_data)
  );

  logic [W-1:0] mdl  [NT][ROWS];
  logic [W-1:0] expr [ROWS];
  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_row();
    logic [W-1:0] r;
    for (int i = 0; i < W / 32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [W-1:0] ref_row(int d, int a, int b, int n);
    logic [W-1:0] r;
    for (int m = 0; m < ROWS; m++) begin
      int s = int'(mdl[d][n][32*m +: 32]);
      for (int j = 0; j < K; j++)
        s += int'($signed(mdl[a][n][8*j +: 8])) * int'($signed(mdl[b][j/4][8*(4*m + j%4) +: 8]));
      r[32*m +: 32] = s;
    end
    return r;
  endfunction

  task automatic wr(input int t, input int r, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_tile = TW'(t); wr_row = RW'(r); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    mdl[t][r] = d;
  endtask

  task automatic rdchk(input int t, input int r, input string req);
    @(negedge clk);
    rd_tile = TW'(t); rd_row = RW'(r);
    #1;
    chk(rd_data === mdl[t][r], req, rd_data, mdl[t][r]);
  endtask

  // mode 0: plain, 1: write and start injected while busy, 2: write with start
  task automatic op(input int d, input int a, input int b, input int mode, input string req);
    @(negedge clk);
    start = 1; cmd_dst = TW'(d); cmd_a = TW'(a); cmd_b = TW'(b);
    if (mode == 2) begin
      logic [W-1:0] nd = rnd_row();
      wr_en = 1; wr_tile = TW'(a); wr_row = 0; wr_data = nd;
      mdl[a][0] = nd;
    end
    for (int n = 0; n < ROWS; n++) expr[n] = ref_row(d, a, b, n);
    @(negedge clk);
    start = 0; wr_en = 0;
    chk(busy === 1'b1, "R6 busy after start", W'(busy), W'(1));
    chk(res_valid === 1'b0, "R9 no row yet", W'(res_valid), W'(0));
    for (int r = 0; r < ROWS; r++) begin
      if (mode == 1 && r == 0) begin
        start = 1; cmd_dst = TW'(a); cmd_a = TW'(b); cmd_b = TW'(d);
        wr_en = 1; wr_tile = TW'(a); wr_row = 0; wr_data = ~mdl[a][0];
      end
      @(negedge clk);
      start = 0; wr_en = 0;
      chk(res_valid === 1'b1 && res_row === RW'(r), "R9 stream index", W'(res_row), W'(r));
      chk(res_data === expr[r], req, res_data, expr[r]);
      chk(busy === (r < ROWS - 1), "R6 busy length", W'(busy), W'(r < ROWS - 1));
      chk(done === (r == ROWS - 1), "R6 done timing", W'(done), W'(r == ROWS - 1));
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, mode == 1 ? "R7 no relaunch" : "R6 done one cycle",
        W'({busy, done}), W'(0));
    for (int n = 0; n < ROWS; n++) mdl[d][n] = expr[n];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && res_valid === 0, "R1 in reset", W'({busy, done, res_valid}), W'(0));
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && res_valid === 0, "R1 after reset", W'({busy, done, res_valid}), W'(0));

    for (int t = 0; t < NT; t++)
      for (int r = 0; r < ROWS; r++) wr(t, r, rnd_row());
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < ROWS; r++) rdchk(t, r, "R2 readback");

    op(2, 0, 1, 0, "R3 random product");
    for (int r = 0; r < ROWS; r++) rdchk(2, r, "R3 stored row");
    for (int r = 0; r < ROWS; r++) begin
      rdchk(0, r, "R11 source A kept");
      rdchk(1, r, "R11 source B kept");
      rdchk(7, r, "R11 other tile kept");
    end
    op(2, 0, 1, 0, "R3 second accumulate");
    op(2, 0, 1, 0, "R3 third accumulate");
    for (int r = 0; r < ROWS; r++) rdchk(2, r, "R3 repeated accumulate");

    for (int r = 0; r < ROWS; r++) begin
      wr(3, r, {K{8'h80}});
      wr(4, r, {K{8'h80}});
      wr(5, r, '0);
      wr(6, r, {ROWS{32'h7FFF_FFF0}});
    end
    op(5, 3, 4, 0, "R4 extreme operands");
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk); rd_tile = 5; rd_row = RW'(r); #1;
      chk(rd_data === {ROWS{32'd262144}}, "R4 -128 squared sum", rd_data, {ROWS{32'd262144}});
    end
    op(6, 3, 4, 0, "R5 wrap row");
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk); rd_tile = 6; rd_row = RW'(r); #1;
      chk(rd_data === {ROWS{32'h7FFF_FFF0 + 32'd262144}}, "R5 wrap value", rd_data,
          {ROWS{32'h7FFF_FFF0 + 32'd262144}});
    end

    op(7, 0, 1, 1, "R3 with interference");
    rdchk(0, 0, "R8 write while busy ignored");
    for (int r = 0; r < ROWS; r++) rdchk(7, r, "R7 single result");

    op(1, 0, 2, 2, "R10 same-cycle write used");
    rdchk(0, 0, "R10 write landed");

    for (int d = 0; d < NT; d++)
      for (int a = 0; a < NT; a++)
        for (int b = 0; b < NT; b++)
          if (d != a && d != b) begin
            op(d, a, b, 0, "R3 sweep");
            rdchk(d, ROWS - 1, "R3 sweep stored");
          end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule